// File: doc/BRIEF.md
# Presettable Up/Down Counter with Dual Count Enables

This block is a synchronous binary counter, four bits wide by default, with a preset path. Clear, load and count requests share one clock edge and follow a fixed priority. Clear wins over everything else. Load comes next and copies the data word into the count. Counting happens only when both count enables are high. A direction input selects whether the counter counts up or down, and the count wraps at the ends of its range in both directions.

A combinational carry output marks the terminal count for the selected direction. That is all-ones when counting up and all-zeros when counting down. The carry is qualified only by the trailing enable, so wider counters can be built by chaining stages. In a chain, each stage's carry drives the next stage's trailing enable, and every stage shares the leading enable and the clock. Because all bits change on the common edge, all stages of a chain update together.

Top module: `preset_counter`

## Requirements
- R1: While rst_ni is low the count is 0, asynchronously to the clock.
- R2: With clr_ni low at a rising edge, the count becomes 0 whatever load_ni, the enables, up_i and data_i are.
- R3: With clr_ni high and load_ni low at a rising edge, the count becomes data_i, with bit k of data_i going to bit k of count_o. The enables are ignored.
- R4: With clr_ni and load_ni high, and en_p_i or en_t_i low, the count holds its value.
- R5: With clr_ni, load_ni, en_p_i, en_t_i and up_i all high, the count increments by one, and all-ones wraps to 0.
- R6: With clr_ni, load_ni, en_p_i and en_t_i high and up_i low, the count decrements by one, and 0 wraps to all-ones.
- R7: carry_o is high exactly when en_t_i is high and the count is at the terminal value for up_i (all-ones for up_i=1, zero for up_i=0). It follows these inputs within the same cycle and does not depend on en_p_i.
- R8: Two instances chained (low stage carry_o driving the high stage en_t_i, en_p_i shared) form a counter twice as wide that counts up and down with correct wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Synchronous clear, active low, top priority |
| load_ni | input | 1 | Synchronous parallel load, active low |
| en_p_i | input | 1 | Leading count enable (counting only) |
| en_t_i | input | 1 | Trailing count enable, also qualifies carry_o |
| up_i | input | 1 | Direction: 1 up, 0 down |
| data_i | input | WIDTH | Parallel load word |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry for cascading |

## Verification
The clocked properties assume that every control input is stable at the rising edge and is a known 0 or 1 while rst_ni is high. They also assume that the whole window from which $past draws lies after reset release. To meet this, the bench changes inputs only mid-cycle, well after each edge, and holds rst_ni high through every sequenced scenario once it is released. The carry properties are checked combinationally in every cycle, so the stimulus sweeps direction and both enables while the count sits on a terminal value as well as off it.

// File: rtl/preset_counter_pkg.sv
package preset_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_op_dec.sv
module cnt_op_dec
  import preset_counter_pkg::*;
(
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);
  // fixed priority: clear > load > count > hold
  always_comb begin
    if (!clr_ni)                op_o = OP_CLEAR;
    else if (!load_ni)          op_o = OP_LOAD;
    else if (en_p_i && en_t_i)  op_o = OP_COUNT;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import preset_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op_i,
  input  logic             up_i,
  input  logic [WIDTH-1:0] count_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] toggle;
  logic [WIDTH-1:0] stepped;

  // parallel toggle enables: one gate level per bit, no serial carry chain
  assign toggle[0] = 1'b1;
  for (genvar i = 1; i < WIDTH; i++) begin : g_tog
    assign toggle[i] = up_i ? (&count_i[i-1:0]) : ~(|count_i[i-1:0]);
  end

  assign stepped = count_i ^ toggle;

  always_comb begin
    unique case (op_i)
      OP_CLEAR: next_o = '0;
      OP_LOAD:  next_o = data_i;
      OP_COUNT: next_o = stepped;
      default:  next_o = count_i;
    endcase
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_i,
  input  logic             en_t_i,
  output logic             carry_o
);
  logic at_max, at_min;
  assign at_max  = &count_i;
  assign at_min  = ~(|count_i);
  assign carry_o = en_t_i & (up_i ? at_max : at_min);
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import preset_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             en_p_i,
  input  logic             en_t_i,
  input  logic             up_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] count_q, count_d;

  cnt_op_dec u_dec (
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .en_p_i (en_p_i),
    .en_t_i (en_t_i),
    .op_o   (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op_i   (op),
    .up_i   (up_i),
    .count_i(count_q),
    .data_i (data_i),
    .next_o (count_d)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .count_i(count_q),
    .up_i   (up_i),
    .en_t_i (en_t_i),
    .carry_o(carry_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             load_ni,
  input logic             en_p_i,
  input logic             en_t_i,
  input logic             up_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (count_o == '0); // R1
  end

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> count_o == '0); // R2
  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> count_o == $past(data_i)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(en_p_i && en_t_i)) |=> $stable(count_o)); // R4
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && en_p_i && en_t_i && up_i)
      |=> count_o == $past(count_o) + ONE); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && en_p_i && en_t_i && !up_i)
      |=> count_o == $past(count_o) - ONE); // R6
  AST_CARRY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_t_i |-> !carry_o); // R7
  AST_CARRY_UP_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_t_i && up_i && count_o == '1) |-> carry_o); // R7
  AST_CARRY_DOWN_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_t_i && !up_i && count_o == '0) |-> carry_o); // R7
  AST_CARRY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_o == '0 || count_o == '1)); // R7
endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/preset_counter_test.sv
module preset_counter_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_ni = 1'b1, load_ni = 1'b1, en_p = 1'b0, en_t = 1'b0, up = 1'b1;
  logic [W-1:0] data = '0;
  logic [W-1:0] count;
  logic carry;

  // cascade pair
  logic c_clr_n = 1'b1, c_load_n = 1'b1, c_en_p = 1'b0, c_en_t = 1'b0, c_up = 1'b1;
  logic [2*W-1:0] c_data = '0;
  logic [W-1:0] lo_cnt, hi_cnt;
  logic lo_carry, hi_carry;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  preset_counter #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(clr_ni), .load_ni(load_ni),
    .en_p_i(en_p), .en_t_i(en_t), .up_i(up), .data_i(data),
    .count_o(count), .carry_o(carry));

  preset_counter #(.WIDTH(W)) u_lo (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(c_clr_n), .load_ni(c_load_n),
    .en_p_i(c_en_p), .en_t_i(c_en_t), .up_i(c_up), .data_i(c_data[W-1:0]),
    .count_o(lo_cnt), .carry_o(lo_carry));

  preset_counter #(.WIDTH(W)) u_hi (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(c_clr_n), .load_ni(c_load_n),
    .en_p_i(c_en_p), .en_t_i(lo_carry), .up_i(c_up), .data_i(c_data[2*W-1:W]),
    .count_o(hi_cnt), .carry_o(hi_carry));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one edge; inputs were set mid-cycle, sample 5 ns after the edge
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic set_ctl(logic c, logic l, logic p, logic t, logic u, logic [W-1:0] d);
    clr_ni = c; load_ni = l; en_p = p; en_t = t; up = u; data = d;
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset count", 8'(count), 8'h0);
    tick();
    check("R1 reset held", 8'(count), 8'h0);
    rst_ni = 1'b1;
    #3;
  endtask

  task automatic t_load();
    set_ctl(1, 0, 0, 0, 1, 4'hA); tick();
    check("R3 load A", 8'(count), 8'hA);
    set_ctl(1, 0, 1, 1, 0, 4'h5); tick();
    check("R3 load over count", 8'(count), 8'h5);
  endtask

  task automatic t_clear();
    set_ctl(0, 0, 1, 1, 1, 4'h9); tick();
    check("R2 clear beats load", 8'(count), 8'h0);
    set_ctl(1, 0, 0, 0, 1, 4'h7); tick();
    set_ctl(0, 1, 1, 1, 0, 4'h3); tick();
    check("R2 clear beats count", 8'(count), 8'h0);
  endtask

  task automatic t_hold();
    set_ctl(1, 0, 0, 0, 1, 4'h6); tick();
    set_ctl(1, 1, 0, 1, 1, 4'hF); tick();
    check("R4 hold en_p low", 8'(count), 8'h6);
    set_ctl(1, 1, 1, 0, 0, 4'hF); tick();
    check("R4 hold en_t low", 8'(count), 8'h6);
    set_ctl(1, 1, 0, 0, 1, 4'h0); tick();
    check("R4 hold both low", 8'(count), 8'h6);
  endtask

  task automatic t_up_wrap();
    set_ctl(1, 0, 0, 0, 1, 4'hE); tick();
    set_ctl(1, 1, 1, 1, 1, 4'h0); #1;
    check("R7 no carry at E", 8'(carry), 8'h0);
    tick();
    check("R5 up to F", 8'(count), 8'hF);
    check("R7 up carry at F", 8'(carry), 8'h1);
    tick();
    check("R5 wrap to 0", 8'(count), 8'h0);
    check("R7 up no carry at 0", 8'(carry), 8'h0);
    tick();
    check("R5 up to 1", 8'(count), 8'h1);
  endtask

  task automatic t_down_wrap();
    set_ctl(1, 0, 0, 0, 0, 4'h1); tick();
    set_ctl(1, 1, 1, 1, 0, 4'h0); tick();
    check("R6 down to 0", 8'(count), 8'h0);
    check("R7 down carry at 0", 8'(carry), 8'h1);
    tick();
    check("R6 wrap to F", 8'(count), 8'hF);
    check("R7 down no carry at F", 8'(carry), 8'h0);
    tick();
    check("R6 down to E", 8'(count), 8'hE);
  endtask

  task automatic t_carry_gate();
    set_ctl(1, 0, 0, 0, 1, 4'hF); tick();
    set_ctl(1, 1, 0, 1, 1, 4'h0); #1;
    check("R7 carry ignores en_p", 8'(carry), 8'h1);
    en_t = 1'b0; #1;
    check("R7 carry gated by en_t", 8'(carry), 8'h0);
    en_t = 1'b1; up = 1'b0; #1;
    check("R7 carry follows dir", 8'(carry), 8'h0);
    set_ctl(1, 0, 0, 0, 0, 4'h0); tick();
    set_ctl(1, 1, 0, 1, 0, 4'h0); #1;
    check("R7 down carry en_p low", 8'(carry), 8'h1);
  endtask

  task automatic t_cascade();
    logic [7:0] exp;
    c_data = 8'hFC; c_load_n = 1'b0; tick();
    c_load_n = 1'b1; c_en_p = 1'b1; c_en_t = 1'b1; c_up = 1'b1;
    exp = 8'hFC;
    check("R8 cascade load", {hi_cnt, lo_cnt}, exp);
    for (int i = 0; i < 20; i++) begin
      tick();
      exp = exp + 8'd1;
      check("R8 cascade up", {hi_cnt, lo_cnt}, exp);
    end
    c_up = 1'b0;
    for (int i = 0; i < 24; i++) begin
      tick();
      exp = exp - 8'd1;
      check("R8 cascade down", {hi_cnt, lo_cnt}, exp);
    end
    c_en_p = 1'b0; tick();
    check("R8 cascade hold", {hi_cnt, lo_cnt}, exp);
    c_clr_n = 1'b0; tick();
    check("R8 cascade clear", {hi_cnt, lo_cnt}, 8'h00);
    c_clr_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load();
    t_clear();
    t_hold();
    t_up_wrap();
    t_down_wrap();
    t_carry_gate();
    t_cascade();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule